// File: doc/BRIEF.md
# Latched Serial-to-Parallel Sink Driver

This block takes a serial bit stream and turns it into eight sink-control outputs. Each rising edge of a shift clock pushes the serial input into the first stage of an eight-stage shift register. The other stages move one place toward the last stage. A separate register clock copies the whole shift register into a storage register in a single step. The storage register drives the eight drain-control outputs through an active-low output enable. A drain output at 1 means that sink is on and pulls current. A drain output at 0 means that sink is off.

The last shift stage is also brought out as a serial cascade output, so several of these blocks can be chained into a longer string. A controller shifts a full frame through the chain and then pulses the register clock once. Every output then changes in the same step, without showing the bits while they move. An active-low clear empties only the shift register, so the outputs keep their latched pattern while a new frame is prepared.

The model is fully synchronous to a system clock `clk`. The shift and register clock lines are sampled on `clk` and edge-detected, so each must be synchronous to `clk`. The clear input is the only asynchronous input.

Top module: `sink_driver_top`

## Requirements
- R1: After reset the storage register holds all zeros: with `outEnN` low every `drainOn` bit is 0, and `serOut` is 0.
- R2: On the `clk` edge where `shiftClk` is first seen high, the shift register moves one place from stage 0 toward stage 7 and `serIn` enters stage 0. Stage i of the shift register maps to bit i of the parallel value.
- R3: Only a rising edge of `shiftClk` shifts. Holding `shiftClk` high for many cycles, or letting it fall, moves nothing.
- R4: On the `clk` edge where `regClk` is first seen high, the storage register takes all eight shift stages. The storage register holds its value at every other time.
- R5: When `shiftClk` and `regClk` rise in the same cycle, the storage register captures the shift contents as they were before that shift.
- R6: While `clearN` is low the shift register is all zeros, and it is cleared at once without waiting for a `clk` edge. The clear wins over a shift edge that comes at the same time, and it leaves the storage register and `drainOn` unchanged.
- R7: When `outEnN` is high every `drainOn` bit is 0, meaning all sinks are off. When `outEnN` is low, `drainOn[i]` equals storage bit i, where 1 means sink on.
- R8: `serOut` always shows stage 7. After a byte has been shifted in, further shifts present its bits on `serOut` from stage 7 down to stage 0, one per shift. Eight shifts therefore pass a whole byte on to the next device in the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and register updates use its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of the whole block |
| serIn | input | 1 | Serial data taken into stage 0 on a shift edge |
| shiftClk | input | 1 | Shift clock line; its rising edges advance the shift register |
| regClk | input | 1 | Register clock line; its rising edges load the storage register |
| clearN | input | 1 | Active-low asynchronous clear of the shift register only |
| outEnN | input | 1 | Active-low output enable; high turns every sink off |
| drainOn | output | 8 | Sink controls; 1 means that sink is on |
| serOut | output | 1 | Cascade output showing the last shift stage |

## Verification
The hardest case to reach is a clear that arrives together with a shift edge while the storage register holds a different, non-zero pattern. The stimulus first latches a known byte and then shifts a second byte in behind it. It drops `clearN` in the middle of a clock period and checks that `serOut` falls before the next edge while `drainOn` keeps the first byte. It then raises `shiftClk` with `serIn` at 1 while the clear is still held. After the clear is released, a load shows that nothing entered the shift register. The same-cycle case of both clocks rising is reached by driving both lines high on a single falling edge of `clk`.

// File: rtl/sink_driver_pkg.sv
package sink_driver_pkg;

  // Strobes from the edge-detect control to the datapath
  typedef struct packed {
    logic shiftStb;  // rising edge seen on the shift clock line
    logic loadStb;   // rising edge seen on the register clock line
  } strobe_t;

  // Index of each sampled clock line inside the control
  localparam int unsigned LINE_SHIFT = 0;
  localparam int unsigned LINE_LOAD  = 1;
  localparam int unsigned NUM_LINES  = 2;

endpackage

// File: rtl/sink_driver_ctrl.sv
module sink_driver_ctrl
  import sink_driver_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    shiftClk,
  input  logic    regClk,
  output strobe_t strobes
);

  logic [NUM_LINES-1:0] lineNow;
  logic [NUM_LINES-1:0] linePrev;
  logic [NUM_LINES-1:0] lineRise;

  always_comb begin
    lineNow             = '0;
    lineNow[LINE_SHIFT] = shiftClk;
    lineNow[LINE_LOAD]  = regClk;
  end

  // One edge detector for each clock line. The previous value resets to 1,
  // so a line that is already high when reset ends does not count as an edge.
  for (genvar g = 0; g < NUM_LINES; g++) begin : gEdge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) linePrev[g] <= 1'b1;
      else       linePrev[g] <= lineNow[g];
    end
    assign lineRise[g] = lineNow[g] & ~linePrev[g];
  end

  assign strobes.shiftStb = lineRise[LINE_SHIFT];
  assign strobes.loadStb  = lineRise[LINE_LOAD];

  // A single rising edge gives a one-cycle strobe, never two in a row
  AST_SHIFT_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftStb |=> !strobes.shiftStb); // R3
  AST_LOAD_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadStb |=> !strobes.loadStb); // R4

endmodule

// File: rtl/sink_driver_datapath.sv
module sink_driver_datapath
  import sink_driver_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             clearN,
  input  logic             outEnN,
  input  strobe_t          strobes,
  output logic [WIDTH-1:0] drainOn,
  output logic             serOut
);

  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] storeReg;

  // Shift register: the asynchronous clear beats any shift edge
  always_ff @(posedge clk or negedge rstN or negedge clearN) begin
    if (!rstN || !clearN)      shiftReg <= '0;
    else if (strobes.shiftStb) shiftReg <= {shiftReg[LAST-1:0], serIn};
  end

  // Storage register: loads the value from before the edge, so a shift in
  // the same cycle does not reach it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                storeReg <= '0;
    else if (strobes.loadStb) storeReg <= shiftReg;
  end

  assign serOut = shiftReg[LAST];

  // Output gate: a high enable forces every sink off
  for (genvar g = 0; g < WIDTH; g++) begin : gGate
    assign drainOn[g] = storeReg[g] & ~outEnN;
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> shiftReg == '0); // R6
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftStb && clearN) |=>
      (!clearN || shiftReg == {$past(shiftReg[LAST-1:0]), $past(serIn)})); // R2
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shiftStb && clearN) |=> (!clearN || $stable(shiftReg))); // R3
  AST_LOAD_PRE_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadStb |=> storeReg == $past(shiftReg)); // R5
  AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadStb |=> $stable(storeReg)); // R4

endmodule

// File: rtl/sink_driver_top.sv
module sink_driver_top
  import sink_driver_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             regClk,
  input  logic             clearN,
  input  logic             outEnN,
  output logic [WIDTH-1:0] drainOn,
  output logic             serOut
);

  strobe_t strobes;

  sink_driver_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftClk (shiftClk),
    .regClk   (regClk),
    .strobes  (strobes)
  );

  sink_driver_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .clearN  (clearN),
    .outEnN  (outEnN),
    .strobes (strobes),
    .drainOn (drainOn),
    .serOut  (serOut)
  );

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> drainOn == '0); // R7

endmodule

// File: tb/tb_sink_driver_top.sv
module tb_sink_driver_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serIn = 1'b0;
  logic       shiftClk = 1'b0;
  logic       regClk = 1'b0;
  logic       clearN = 1'b1;
  logic       outEnN = 1'b0;
  logic [7:0] drainOn;
  logic       serOut;

  int errors = 0;
  int checks = 0;
  logic [7:0] expSh = '0;   // expected shift register contents
  logic [7:0] expSt = '0;   // expected storage register contents

  always #10ns clk = ~clk;  // 50 MHz

  sink_driver_top dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftClk(shiftClk),
    .regClk(regClk), .clearN(clearN), .outEnN(outEnN),
    .drainOn(drainOn), .serOut(serOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one shift: the line goes high at a falling edge and low at the next one
  task automatic doShift(input logic b);
    @(negedge clk); serIn = b; shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0;
    expSh = {expSh[6:0], b};
  endtask

  task automatic doLoad();
    @(negedge clk); regClk = 1'b1;
    @(negedge clk); regClk = 1'b0;
    expSt = expSh;
  endtask

  task automatic shiftByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) doShift(v[i]);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 drainOn after reset", drainOn, 8'h00);
    chk("R1 serOut after reset", {7'd0, serOut}, 8'h00);

    // R2 R7 R8: sweep every byte value
    for (int v = 0; v < 256; v++) begin
      shiftByte(v[7:0]);
      chk("R8 serOut is stage 7", {7'd0, serOut}, {7'd0, expSh[7]});
      doLoad();
      outEnN = 1'b0; #1;
      chk("R2 parallel value", drainOn, v[7:0]);
      outEnN = 1'b1; #1;
      chk("R7 enable high forces off", drainOn, 8'h00);
      outEnN = 1'b0;
    end

    // R8: cascade, the byte leaves by serOut, stage 7 first
    shiftByte(8'hB4);
    for (int k = 7; k >= 0; k--) begin
      chk("R8 cascade bit", {7'd0, serOut}, {7'd0, expSh[7]});
      doShift(1'b0);
    end
    chk("R8 emptied after eight shifts", {7'd0, serOut}, 8'h00);

    // R3: line held high for several cycles gives one shift only
    shiftByte(8'h00);
    @(negedge clk); serIn = 1'b1; shiftClk = 1'b1;
    repeat (5) @(negedge clk);
    serIn = 1'b0; shiftClk = 1'b0;
    repeat (3) @(negedge clk);
    expSh = 8'h01;
    doLoad(); #1;
    chk("R3 single shift while held", drainOn, 8'h01);

    // R4: storage holds while shifting continues
    shiftByte(8'h5A);
    #1;
    chk("R4 storage holds without load", drainOn, 8'h01);
    doLoad(); #1;
    chk("R4 load copies shift register", drainOn, 8'h5A);

    // R5: both lines rise in the same cycle
    @(negedge clk); serIn = 1'b1; shiftClk = 1'b1; regClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0; regClk = 1'b0;
    #1;
    chk("R5 storage sees pre-shift value", drainOn, 8'h5A);
    expSh = 8'hB5;
    doLoad(); #1;
    chk("R5 shift still happened", drainOn, 8'hB5);

    // R6: clear mid-period with a different latched pattern
    shiftByte(8'hFF);
    @(negedge clk); #2 clearN = 1'b0; #1;
    chk("R6 clear acts without clock edge", {7'd0, serOut}, 8'h00);
    chk("R6 storage untouched", drainOn, 8'hB5);
    @(negedge clk); serIn = 1'b1; shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0;
    @(negedge clk); clearN = 1'b1;
    expSh = 8'h00;
    #1;
    chk("R6 drainOn kept during clear", drainOn, 8'hB5);
    doLoad(); #1;
    chk("R6 clear beats shift edge", drainOn, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule